// File: doc/BRIEF.md
# Tick-Driven Real-Time-Clock Interrupt Emulator

This block rebuilds the three classic real-time-clock interrupt sources from one programmable compare channel that watches a free-running counter. The sources are a once-per-second update, an alarm at a chosen time of day, and a periodic interrupt at a power-of-two rate. The block keeps its own compare value. Whenever the counter reaches that value, the block samples the current hours, minutes and seconds, works out which sources fire, and emits a one-cycle interrupt strobe together with a status word.

The tick normally runs at a 64 Hz base rate. The `baseDelta` input gives the number of counter units in one base tick. A periodic request at or below the base rate keeps that tick and divides it down by counting ticks. A faster request shortens the tick itself. If the counter has run past several compare points before the block reacts, the compare value is stepped forward one delta per cycle until it lies ahead of the counter again. The skipped steps are counted as lost ticks and credited to the periodic divider.

Top module: `rtcTickEmu`

## Requirements
- R1: After reset, `chanOn`, `irqStrobe` and `statusWord` are all zero.
- R2: While the channel is off, if any of `updEn`, `almEn` or `perEn` is high at a clock edge, the channel turns on at that edge. `cmpVal` becomes `cntNow + delta` and the periodic tick count is cleared.
- R3: While the channel is on, if all three enables are low at a clock edge, `chanOn` drops at that edge. After that, `cmpVal` is frozen and no strobe is produced, whatever the counter does.
- R4: A tick is due when `cntNow - cmpVal`, taken as a CW-bit two's-complement value, is zero or positive. When the counter wraps, a compare value just past zero is therefore still ahead of a counter just below the top.
- R5: On a tick, `cmpVal` is advanced by one delta per cycle and stops at the first value where `cntNow - cmpVal` (signed) is zero or negative. Every step after the first counts as one lost tick.
- R6: `rateSel` selects a periodic rate of 2^rateSel Hz. Values below 1 are treated as 1 and values above 13 are treated as 13. When `perEn` is high and the clamped value exceeds 6, delta is `baseDelta >> (rateSel-6)`. Otherwise delta is `baseDelta`.
- R7: On a tick with `perEn` high, the periodic count becomes count + lost + 1. The periodic flag fires when this sum reaches 2^(6-rateSel), or 1 for rates above 64 Hz, and the count then returns to zero.
- R8: With `updEn` high, the update flag fires when the seconds value sampled at the tick differs from the stored seconds. The stored seconds value is refreshed only when the flag fires, and it resets to 0.
- R9: With `almEn` high, the alarm flag fires when the sampled seconds, minutes and hours all equal `almSec`, `almMin` and `almHr`.
- R10: When at least one flag fires, `irqStrobe` is high for exactly one cycle. In that cycle `statusWord` has bit 7 as the summary IRQ flag, bit 6 as periodic, bit 5 as alarm, bit 4 as update, bits 15:8 equal to 1 and all other bits zero. A tick where no flag fires gives no strobe.
- R11: `statusWord` changes only together with a strobe and otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntNow | input | CW | Free-running counter value |
| baseDelta | input | CW | Counter units per 64 Hz base tick |
| updEn | input | 1 | Update interrupt enable |
| almEn | input | 1 | Alarm interrupt enable |
| perEn | input | 1 | Periodic interrupt enable |
| rateSel | input | 4 | Periodic rate exponent (2^rateSel Hz) |
| secNow | input | 6 | Current seconds |
| minNow | input | 6 | Current minutes |
| hrNow | input | 5 | Current hours |
| almSec | input | 6 | Alarm seconds |
| almMin | input | 6 | Alarm minutes |
| almHr | input | 5 | Alarm hours |
| chanOn | output | 1 | Compare channel active |
| cmpVal | output | CW | Scheduled compare value |
| irqStrobe | output | 1 | One-cycle interrupt strobe |
| statusWord | output | 16 | Interrupt status word |

## Verification
The assertions assume that `baseDelta` is nonzero, so that every catch-up sequence ends. They also assume that the counter does not move more than half its range between two ticks, so that the signed compare stays meaningful. The stimulus holds `baseDelta` at 1024, which keeps even the largest clamped shift nonzero. It moves the counter only between ticks and by well under half the range, and it changes enables and time of day only while the block is waiting for a tick. This lets a reference model in the bench predict each compare value and status word exactly.

// File: rtl/rtcEmuPkg.sv
package rtcEmuPkg;
  localparam int BASE_LOG2 = 6;
  localparam int RATE_MIN  = 1;
  localparam int RATE_MAX  = 13;
  localparam int BIT_IRQ   = 7;
  localparam int BIT_PER   = 6;
  localparam int BIT_ALM   = 5;
  localparam int BIT_UPD   = 4;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_WAIT = 2'd1,
    ST_STEP = 2'd2,
    ST_EVAL = 2'd3
  } emuState_t;

  typedef struct packed {
    logic startLoad;
    logic sampleTod;
    logic stepCmp;
    logic countLost;
    logic evalTick;
  } ctrlStrb_t;
endpackage

// File: rtl/rtcEmuCtrl.sv
module rtcEmuCtrl
  import rtcEmuPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      anyEn,
  input  logic      tickDue,
  input  logic      stepAhead,
  output ctrlStrb_t strb,
  output logic      chanOn
);
  emuState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_OFF: if (anyEn) begin
        strb.startLoad = 1'b1;
        stateNext      = ST_WAIT;
      end
      ST_WAIT: begin
        if (!anyEn) stateNext = ST_OFF;
        else if (tickDue) begin
          strb.sampleTod = 1'b1;
          stateNext      = ST_STEP;
        end
      end
      ST_STEP: begin
        strb.stepCmp = 1'b1;
        if (stepAhead) stateNext = ST_EVAL;
        else strb.countLost = 1'b1;
      end
      ST_EVAL: begin
        strb.evalTick = 1'b1;
        stateNext     = ST_WAIT;
      end
      default: stateNext = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNext;
  end

  assign chanOn = (state != ST_OFF);
endmodule

// File: rtl/rtcEmuDatapath.sv
module rtcEmuDatapath
  import rtcEmuPkg::*;
#(
  parameter int CW = 32,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrb_t     strb,
  input  logic [CW-1:0] cntNow,
  input  logic [CW-1:0] baseDelta,
  input  logic          updEn,
  input  logic          almEn,
  input  logic          perEn,
  input  logic [3:0]    rateSel,
  input  logic [5:0]    secNow,
  input  logic [5:0]    minNow,
  input  logic [4:0]    hrNow,
  input  logic [5:0]    almSec,
  input  logic [5:0]    almMin,
  input  logic [4:0]    almHr,
  output logic [CW-1:0] cmpVal,
  output logic          tickDue,
  output logic          stepAhead,
  output logic          irqStrobe,
  output logic [15:0]   statusWord
);
  localparam logic [3:0] RMIN = 4'(RATE_MIN);
  localparam logic [3:0] RMAX = 4'(RATE_MAX);
  localparam logic [3:0] RBASE = 4'(BASE_LOG2);

  logic [3:0]    rateC;
  logic          fastRate;
  logic [CW-1:0] delta, cmpNext, diffNow, diffNext;
  logic [PW-1:0] pieLimit, pieCnt, lostCnt, pieSum;
  logic [5:0]    prevSec, sSec, sMin;
  logic [4:0]    sHr;
  logic          updF, perF, almF, anyF;

  always_comb begin
    if (rateSel < RMIN)      rateC = RMIN;
    else if (rateSel > RMAX) rateC = RMAX;
    else                     rateC = rateSel;
    fastRate = perEn && (rateC > RBASE);
    delta    = fastRate ? (baseDelta >> (rateC - RBASE)) : baseDelta;
    pieLimit = fastRate ? PW'(1) : (PW'(1) << (RBASE - rateC));
    cmpNext  = cmpVal + delta;
    diffNow  = cntNow - cmpVal;
    diffNext = cntNow - cmpNext;
    tickDue  = !diffNow[CW-1];
    stepAhead = diffNext[CW-1] || (diffNext == '0);
    pieSum   = pieCnt + lostCnt + PW'(1);
    updF     = updEn && (sSec != prevSec);
    perF     = perEn && (pieSum >= pieLimit);
    almF     = almEn && (sSec == almSec) && (sMin == almMin) && (sHr == almHr);
    anyF     = updF || perF || almF;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpVal     <= '0;
      lostCnt    <= '0;
      pieCnt     <= '0;
      prevSec    <= '0;
      sSec       <= '0;
      sMin       <= '0;
      sHr        <= '0;
      irqStrobe  <= 1'b0;
      statusWord <= '0;
    end else begin
      irqStrobe <= 1'b0;
      if (strb.startLoad) begin
        cmpVal  <= cntNow + delta;
        pieCnt  <= '0;
        lostCnt <= '0;
      end
      if (strb.sampleTod) begin
        sSec <= secNow;
        sMin <= minNow;
        sHr  <= hrNow;
      end
      if (strb.stepCmp)   cmpVal  <= cmpNext;
      if (strb.countLost) lostCnt <= lostCnt + PW'(1);
      if (strb.evalTick) begin
        lostCnt <= '0;
        if (perEn) pieCnt <= perF ? '0 : pieSum;
        if (updF) prevSec <= sSec;
        irqStrobe <= anyF;
        if (anyF) begin
          statusWord          <= 16'h0100;
          statusWord[BIT_IRQ] <= 1'b1;
          statusWord[BIT_PER] <= perF;
          statusWord[BIT_ALM] <= almF;
          statusWord[BIT_UPD] <= updF;
        end
      end
    end
  end
endmodule

// File: rtl/rtcTickEmu.sv
module rtcTickEmu
  import rtcEmuPkg::*;
#(
  parameter int CW = 32,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CW-1:0] cntNow,
  input  logic [CW-1:0] baseDelta,
  input  logic          updEn,
  input  logic          almEn,
  input  logic          perEn,
  input  logic [3:0]    rateSel,
  input  logic [5:0]    secNow,
  input  logic [5:0]    minNow,
  input  logic [4:0]    hrNow,
  input  logic [5:0]    almSec,
  input  logic [5:0]    almMin,
  input  logic [4:0]    almHr,
  output logic          chanOn,
  output logic [CW-1:0] cmpVal,
  output logic          irqStrobe,
  output logic [15:0]   statusWord
);
  ctrlStrb_t strb;
  logic tickDue, stepAhead;

  rtcEmuCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .anyEn(updEn | almEn | perEn),
    .tickDue(tickDue), .stepAhead(stepAhead), .strb(strb), .chanOn(chanOn)
  );

  rtcEmuDatapath #(.CW(CW), .PW(PW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cntNow(cntNow), .baseDelta(baseDelta),
    .updEn(updEn), .almEn(almEn), .perEn(perEn), .rateSel(rateSel),
    .secNow(secNow), .minNow(minNow), .hrNow(hrNow),
    .almSec(almSec), .almMin(almMin), .almHr(almHr),
    .cmpVal(cmpVal), .tickDue(tickDue), .stepAhead(stepAhead),
    .irqStrobe(irqStrobe), .statusWord(statusWord)
  );
endmodule

// File: rtl/rtcEmuChk.sv
module rtcEmuChk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          chanOn,
  input logic [CW-1:0] cmpVal,
  input logic          irqStrobe,
  input logic [15:0]   statusWord
);
  // R10
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqStrobe |=> !irqStrobe);
  // R10
  status_format_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqStrobe |-> (statusWord[15:8] == 8'd1 && statusWord[7] &&
                   statusWord[6:4] != 3'b000 && statusWord[3:0] == 4'd0));
  // R11
  status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqStrobe |-> $stable(statusWord));
  // R3
  strobe_needs_chan_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqStrobe |-> chanOn);
  // R3
  cmp_frozen_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!chanOn && !$past(chanOn)) |-> $stable(cmpVal));
endmodule

bind rtcTickEmu rtcEmuChk #(.CW(CW)) u_chk (
  .clk(clk), .rstN(rstN), .chanOn(chanOn), .cmpVal(cmpVal),
  .irqStrobe(irqStrobe), .statusWord(statusWord)
);

// File: tb/test_rtcTickEmu.sv
module test_rtcTickEmu;
  localparam int CW = 32;
  logic clk = 1'b0, rstN = 1'b0;
  logic [CW-1:0] cntNow = '0, baseDelta = 32'd1024;
  logic updEn = 0, almEn = 0, perEn = 0;
  logic [3:0] rateSel = 4'd6;
  logic [5:0] secNow = 0, minNow = 0, almSec = 0, almMin = 0;
  logic [4:0] hrNow = 0, almHr = 0;
  logic chanOn, irqStrobe;
  logic [CW-1:0] cmpVal;
  logic [15:0] statusWord;

  int nCmp = 0, nBad = 0;
  logic [15:0] expQ[$];
  string reqQ[$];
  logic [15:0] lastStatus = 16'h0;

  logic mOn = 0;
  logic [CW-1:0] mCmp = '0;
  int mPie = 0;
  logic [5:0] mPrevSec = 0;

  always #2.5 clk = ~clk;

  rtcTickEmu #(.CW(CW)) i_rtcTickEmu (
    .clk(clk), .rstN(rstN), .cntNow(cntNow), .baseDelta(baseDelta),
    .updEn(updEn), .almEn(almEn), .perEn(perEn), .rateSel(rateSel),
    .secNow(secNow), .minNow(minNow), .hrNow(hrNow),
    .almSec(almSec), .almMin(almMin), .almHr(almHr),
    .chanOn(chanOn), .cmpVal(cmpVal), .irqStrobe(irqStrobe), .statusWord(statusWord)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops expected status words as strobes appear
  always @(negedge clk) begin
    if (rstN && irqStrobe) begin
      nCmp++;
      if (expQ.size() == 0) begin
        nBad++;
        $display("FAIL R10: actual strobe status %h expected no strobe", statusWord);
      end else begin
        logic [15:0] e;
        string r;
        e = expQ.pop_front();
        r = reqQ.pop_front();
        if (statusWord !== e) begin
          nBad++;
          $display("FAIL %s: actual %h expected %h", r, statusWord, e);
        end
      end
    end
  end

  function automatic int rateClamp();
    if (rateSel < 1) return 1;
    if (rateSel > 13) return 13;
    return int'(rateSel);
  endfunction

  function automatic logic [CW-1:0] mDelta();
    int r = rateClamp();
    if (perEn && r > 6) return baseDelta >> (r - 6);
    return baseDelta;
  endfunction

  function automatic int mLimit();
    int r = rateClamp();
    if (perEn && r > 6) return 1;
    return 1 << (6 - r);
  endfunction

  task automatic setEn(input logic u, input logic a, input logic p);
    @(negedge clk);
    updEn = u; almEn = a; perEn = p;
    if (!mOn && (u || a || p)) begin
      mOn = 1; mCmp = cntNow + mDelta(); mPie = 0;
    end else if (mOn && !(u || a || p)) mOn = 0;
    repeat (2) @(negedge clk);
  endtask

  // drive counter to a value that makes a tick due, model the outcome
  task automatic tick(input logic [CW-1:0] newCnt, input string req);
    logic [CW-1:0] d, diff;
    int lost;
    logic uf, pf, af;
    logic [15:0] e;
    @(negedge clk);
    cntNow = newCnt;
    d = mDelta();
    lost = -1;
    do begin
      mCmp = mCmp + d;
      lost++;
      diff = newCnt - mCmp;
    end while ($signed(diff) > 0);
    uf = updEn && (secNow != mPrevSec);
    if (uf) mPrevSec = secNow;
    pf = 0;
    if (perEn) begin
      mPie = mPie + lost + 1;
      if (mPie >= mLimit()) begin pf = 1; mPie = 0; end
    end
    af = almEn && secNow == almSec && minNow == almMin && hrNow == almHr;
    if (uf || pf || af) begin
      e = 16'h0180 | (pf ? 16'h40 : 16'h0) | (af ? 16'h20 : 16'h0) | (uf ? 16'h10 : 16'h0);
      expQ.push_back(e);
      reqQ.push_back(req);
      lastStatus = e;
    end
    repeat (lost + 6) @(negedge clk);
    chk({req, " cmp"}, cmpVal, mCmp);
    chk({req, " status"}, {16'h0, statusWord}, {16'h0, lastStatus});
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(negedge clk);
        nBad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
      begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 chanOn", {31'h0, chanOn}, 0);
        chk("R1 strobe", {31'h0, irqStrobe}, 0);
        chk("R1 status", {16'h0, statusWord}, 0);
        rstN = 1;
        @(negedge clk);
        // R2 start scheduling
        cntNow = 1000; secNow = 5;
        setEn(1, 0, 0);
        chk("R2 chanOn", {31'h0, chanOn}, 1);
        chk("R2 cmp", cmpVal, 32'd2024);
        // R8 update fires on seconds change
        tick(32'd2024, "R8");
        // R11 same seconds: no strobe, status held
        tick(mCmp, "R11");
        // R5 R7 lost ticks feed divider at 32 Hz
        rateSel = 4'd5;
        setEn(0, 0, 1);
        tick(mCmp + 32'd3500, "R5");
        tick(mCmp, "R7");
        tick(mCmp, "R7");
        // R6 fast rate shortens delta
        rateSel = 4'd9;
        tick(mCmp, "R6");
        tick(mCmp + 32'd300, "R5");
        rateSel = 4'd15;
        tick(mCmp, "R6");
        rateSel = 4'd0;
        tick(mCmp, "R6");
        tick(mCmp + 32'd40000, "R7");
        // R9 alarm
        almSec = 3; almMin = 2; almHr = 1;
        secNow = 3; minNow = 2; hrNow = 1;
        setEn(0, 1, 0);
        tick(mCmp, "R9");
        minNow = 4;
        tick(mCmp, "R9");
        // R10 all three at once
        rateSel = 4'd9; minNow = 2;
        setEn(1, 1, 1);
        tick(mCmp, "R10");
        // R3 disable
        setEn(0, 0, 0);
        chk("R3 chanOn", {31'h0, chanOn}, 0);
        cntNow = mCmp + 32'd5000;
        repeat (10) @(negedge clk);
        chk("R3 cmp frozen", cmpVal, mCmp);
        // R4 wrap
        cntNow = 32'hFFFF_FF00;
        setEn(1, 0, 0);
        chk("R4 cmp wrapped", cmpVal, 32'h0000_0300);
        cntNow = 32'hFFFF_FFF0;
        repeat (8) @(negedge clk);
        chk("R4 no early tick", cmpVal, 32'h0000_0300);
        secNow = 9;
        tick(32'h0000_0300, "R4");
        repeat (4) @(negedge clk);
        chk("R10 queue drained", expQ.size(), 0);
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule